// File: doc/BRIEF.md
# Phase-Aligned Binary Clock Divider

This block derives a family of divided clocks from a primary clock input A. It also carries three auxiliary clock-like inputs B, C and D through a matched stage. All four inputs and all outputs are modelled as registered signals sampled by the block clock `clk`. Every input passes through one identical register stage, so the four matched outputs keep the phase relation and the duty cycle their inputs had. The divided outputs come from a down-counter that steps only when the matched copy of A rises. Every divided edge therefore lands on a rising edge of the matched A output. Each divided output has a 50 percent duty cycle, whatever the duty cycle of A.

Reset is asserted asynchronously and is released through a two-stage synchronizer. That synchronizer advances only on rising edges of one input, chosen by a parameter. An optional release gate keeps the divided outputs low after reset until a strobe, sampled on a rising edge of A, allows them to start. Designers use the block where slow clocks must stay edge-aligned to a fast one. It also suits a group of related clocks that must leave the block with matched latency.

Top module: `clkdiv_aligned`

## Requirements
- R1: While `rstN` is low, every bit of `clkOut` and `divOut` is 0. Assertion of `rstN` clears them at once, without waiting for a `clk` edge, and also clears the divide count, the synchronizer and the release state.
- R2: `clkIn` bit 0 is input A and bits 1 to 3 are B, C and D. Out of reset, each `clkOut` bit equals the matching `clkIn` bit sampled at the previous `clk` edge, with the same one-cycle latency for all four bits.
- R3: `divOut` bit k divides A by 2^(k+1). It changes only on `clk` edges where A rises, meaning A is 1 now and was 0 at the previous sampled edge. Once started, it is high for 2^k rising edges of A and then low for 2^k.
- R4: Every `divOut` bit rises together on the first counted rising edge of A. Any rising edge of a divided output coincides with a rising edge of `clkOut` bit 0.
- R5: Once `rstN` goes high, the reset release completes on the second rising edge of the input chosen by `RST_SYNC_SEL`. The values 0 to 3 select A to D, and A is the default. Until the release completes, `divOut` stays 0.
- R6: With `RELEASE_GATE` = 0, counting begins at the first rising edge of A after the reset release has completed. `relStrobe` has no effect on any output.
- R7: With `RELEASE_GATE` = 1, `divOut` stays 0 until `relStrobe` is high on a rising edge of A after the reset release has completed. A strobe at any other time is ignored. Counting starts at the next rising edge of A, and the release holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples every clock-like input |
| rstN | input | 1 | Active-low reset, asserted asynchronously |
| clkIn | input | NUM_IN | Clock-like inputs; bit 0 is the primary input A |
| relStrobe | input | 1 | Release strobe, sampled on rising edges of A |
| clkOut | output | NUM_IN | Matched-latency copies of `clkIn` |
| divOut | output | DIV_STAGES | Divided outputs; bit k divides A by 2^(k+1) |

## Verification
The assertions check these properties on every cycle:
- the matched one-cycle latency of all four inputs;
- divided outputs that move only on a rising edge of A;
- divided rising edges that coincide with the rising edge of the matched A output;
- each divided bit toggling only as the bit below it rises;
- divided outputs held at zero before the reset release, and before the gate opens.

Some behaviour only the bench scenarios can show. These include the exact edge on which counting starts after release through input A and through input C, and the 50 percent duty cycle when A is skewed. They also include strobes that are ignored because they miss a rising edge of A or arrive before the reset release, the gate staying released, and the outputs clearing at once on an asynchronous reset in mid-run.

// File: rtl/clkdiv_aligned_pkg.sv
package clkdiv_aligned_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic step;   // advance the divide counter on this cycle
    logic clear;  // hold the divide counter at zero
  } dpStrobe_t;

endpackage

// File: rtl/clkdiv_aligned_dp.sv
module clkdiv_aligned_dp
  import clkdiv_aligned_pkg::*;
#(
  parameter int NUM_IN     = 4,
  parameter int DIV_STAGES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_IN-1:0]     clkIn,
  input  dpStrobe_t             strobe,
  output logic [NUM_IN-1:0]     clkOut,
  output logic [NUM_IN-1:0]     riseVec,
  output logic [DIV_STAGES-1:0] divOut
);

  logic [NUM_IN-1:0]     matchQ;
  logic [DIV_STAGES-1:0] cntQ;

  // One identical register per input keeps the latency matched.
  for (genvar i = 0; i < NUM_IN; i++) begin : genMatch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) matchQ[i] <= 1'b0;
      else       matchQ[i] <= clkIn[i];
    end
    // Rising edge seen at the matched output on the coming edge.
    assign riseVec[i] = clkIn[i] & ~matchQ[i];
  end

  // Down-counter: all bits rise together on the first step from zero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= '0;
    else if (strobe.clear) cntQ <= '0;
    else if (strobe.step)  cntQ <= cntQ - 1'b1;
  end

  assign clkOut = matchQ;
  assign divOut = cntQ;

endmodule

// File: rtl/clkdiv_aligned_ctrl.sv
module clkdiv_aligned_ctrl
  import clkdiv_aligned_pkg::*;
#(
  parameter int NUM_IN       = 4,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_SYNC_SEL = 0,
  parameter bit RELEASE_GATE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] riseVec,
  input  logic              relStrobe,
  output dpStrobe_t         strobe,
  output logic              syncDone,
  output logic              released
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   primaryRise;
  logic                   runNow;

  assign primaryRise = riseVec[0];

  // Reset release synchronizer, advanced by the selected input's rising edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      syncQ <= '0;
    else if (riseVec[RST_SYNC_SEL]) syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end

  assign syncDone = syncQ[SYNC_STAGES-1];

  if (RELEASE_GATE) begin : genGate
    logic relQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     relQ <= 1'b0;
      else if (syncDone && primaryRise && relStrobe) relQ <= 1'b1;
    end
    assign released = relQ;
  end else begin : genNoGate
    logic unusedRel;
    assign unusedRel = relStrobe;
    assign released  = 1'b1;
  end

  assign runNow       = syncDone & released;
  assign strobe.step  = runNow & primaryRise;
  assign strobe.clear = ~runNow;

endmodule

// File: rtl/clkdiv_aligned.sv
module clkdiv_aligned
  import clkdiv_aligned_pkg::*;
#(
  parameter int NUM_IN       = 4,
  parameter int DIV_STAGES   = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_SYNC_SEL = 0,
  parameter bit RELEASE_GATE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_IN-1:0]     clkIn,
  input  logic                  relStrobe,
  output logic [NUM_IN-1:0]     clkOut,
  output logic [DIV_STAGES-1:0] divOut
);

  dpStrobe_t         strobe;
  logic [NUM_IN-1:0] riseVec;
  logic              syncDone;
  logic              released;

  clkdiv_aligned_ctrl #(
    .NUM_IN       (NUM_IN),
    .SYNC_STAGES  (SYNC_STAGES),
    .RST_SYNC_SEL (RST_SYNC_SEL),
    .RELEASE_GATE (RELEASE_GATE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .riseVec   (riseVec),
    .relStrobe (relStrobe),
    .strobe    (strobe),
    .syncDone  (syncDone),
    .released  (released)
  );

  clkdiv_aligned_dp #(
    .NUM_IN     (NUM_IN),
    .DIV_STAGES (DIV_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .clkIn   (clkIn),
    .strobe  (strobe),
    .clkOut  (clkOut),
    .riseVec (riseVec),
    .divOut  (divOut)
  );

endmodule

// File: rtl/clkdiv_aligned_chk.sv
module clkdiv_aligned_chk #(
  parameter int NUM_IN       = 4,
  parameter int DIV_STAGES   = 3,
  parameter int RST_SYNC_SEL = 0,
  parameter bit RELEASE_GATE = 1'b0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_IN-1:0]     clkIn,
  input logic                  relStrobe,
  input logic [NUM_IN-1:0]     clkOut,
  input logic [DIV_STAGES-1:0] divOut,
  input logic                  syncDone,
  input logic                  released
);

  assert_matched_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> clkOut == $past(clkIn));

  assert_div_on_arise_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !($past(clkIn[0]) && !$past(clkOut[0]))) |-> $stable(divOut));

  assert_rise_aligned_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (|(divOut & ~$past(divOut)))) |-> (clkOut[0] && !$past(clkOut[0])));

  for (genvar k = 1; k < DIV_STAGES; k++) begin : genRatio
    assert_half_rate_R3: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && (divOut[k] != $past(divOut[k]))) |-> (divOut[k-1] && !$past(divOut[k-1])));
  end

  assert_hold_before_sync_R5: assert property (@(posedge clk) disable iff (!rstN)
    !syncDone |-> divOut == '0);

  assert_sync_on_select_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncDone) |-> $past(clkIn[RST_SYNC_SEL] && !clkOut[RST_SYNC_SEL]));

  if (RELEASE_GATE) begin : genGateChk
    assert_gate_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      !released |-> divOut == '0);

    assert_release_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
      $rose(released) |-> $past(relStrobe && syncDone && clkIn[0] && !clkOut[0]));
  end else begin : genNoGateChk
    logic unusedIn;
    assign unusedIn = relStrobe ^ released;
  end

endmodule

bind clkdiv_aligned clkdiv_aligned_chk #(
  .NUM_IN       (NUM_IN),
  .DIV_STAGES   (DIV_STAGES),
  .RST_SYNC_SEL (RST_SYNC_SEL),
  .RELEASE_GATE (RELEASE_GATE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clkIn     (clkIn),
  .relStrobe (relStrobe),
  .clkOut    (clkOut),
  .divOut    (divOut),
  .syncDone  (syncDone),
  .released  (released)
);

// File: tb/clkdiv_aligned_tb.sv
module clkdiv_aligned_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] clkIn;
  logic       relStrobe;
  logic [3:0] outA, outB;
  logic [2:0] divA, divB;

  always #2 clk = ~clk;  // 250 MHz

  clkdiv_aligned u_dut (
    .clk(clk), .rstN(rstN), .clkIn(clkIn), .relStrobe(relStrobe),
    .clkOut(outA), .divOut(divA)
  );

  clkdiv_aligned #(.RST_SYNC_SEL(2), .RELEASE_GATE(1'b1)) u_dutGate (
    .clk(clk), .rstN(rstN), .clkIn(clkIn), .relStrobe(relStrobe),
    .clkOut(outB), .divOut(divB)
  );

  typedef struct {
    logic [3:0] expPass;
    logic [2:0] expDiv0;
    logic [2:0] expDiv1;
    string      tagPass;
    string      tag0;
    string      tag1;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad = 0;
  bit    finished = 0;

  // Reference state per instance: 0 = default, 1 = select C with gate.
  logic [3:0] prevV = '0;
  int         syncCnt[2] = '{0, 0};
  bit         relDone[2] = '{0, 0};
  int         nCnt[2]    = '{0, 0};
  int         selOf[2]   = '{0, 2};
  bit         gateOf[2]  = '{1'b0, 1'b1};

  function automatic logic [2:0] divExpect(int n);
    logic [2:0] r;
    for (int k = 0; k < 3; k++)
      r[k] = (n > 0) && (((n - 1) % (2 << k)) < (1 << k));
    return r;
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs.
  task automatic step(input logic r, input logic [3:0] v, input logic rel);
    item_t it;
    string tg[2];
    @(negedge clk);
    rstN = r; clkIn = v; relStrobe = rel;
    if (!r) begin
      prevV = '0;
      for (int i = 0; i < 2; i++) begin
        syncCnt[i] = 0; relDone[i] = 0; nCnt[i] = 0; tg[i] = "R1";
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit aR, sR, run;
        aR  = v[0] && !prevV[0];
        sR  = v[selOf[i]] && !prevV[selOf[i]];
        run = (syncCnt[i] >= 2) && (!gateOf[i] || relDone[i]);
        if (run && aR) nCnt[i]++;
        if (syncCnt[i] < 2)                     tg[i] = "R5";
        else if (gateOf[i] && !relDone[i])      tg[i] = "R7";
        else if (run && aR && nCnt[i] == 1)     tg[i] = "R4";
        else if (!gateOf[i] && rel)             tg[i] = "R6";
        else                                    tg[i] = "R3";
        if (gateOf[i] && syncCnt[i] >= 2 && aR && rel) relDone[i] = 1;
        if (sR && syncCnt[i] < 2) syncCnt[i]++;
      end
      prevV = v;
    end
    it.expPass = r ? v : 4'b0;
    it.expDiv0 = divExpect(nCnt[0]);
    it.expDiv1 = divExpect(nCnt[1]);
    it.tagPass = r ? "R2" : "R1";
    it.tag0 = tg[0];
    it.tag1 = tg[1];
    q.push_back(it);
  endtask

  task automatic runWave(input logic r, int cycles, int aPer, int aHigh,
                         int relAt, int relLen);
    for (int t = 0; t < cycles; t++) begin
      logic [3:0] v;
      logic rel;
      v[0] = (t % aPer) < aHigh;
      v[1] = ((t + aPer / 4) % aPer) < aHigh;
      v[2] = ((t + 1) % (2 * aPer)) < aPer;
      v[3] = (t % 5) < 2;
      rel  = (t >= relAt) && (t < relAt + relLen);
      step(r, v, rel);
    end
  endtask

  // Monitor: compares each queued item just after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checkVal(it.tagPass, "clkOut default", outA, it.expPass);
        checkVal(it.tagPass, "clkOut gated", outB, it.expPass);
        checkVal(it.tag0, "divOut default", divA, it.expDiv0);
        checkVal(it.tag1, "divOut gated", divB, it.expDiv1);
      end
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; clkIn = '0; relStrobe = 1'b0;
    // R1: reset held with toggling inputs
    runWave(1'b0, 6, 4, 2, 0, 6);
    // R5/R7: sync through A and through C; strobe misses a rising edge of A
    runWave(1'b1, 60, 4, 2, 30, 2);
    // R7: strobe on a rising edge of A opens the gate; R6: default ignores it
    runWave(1'b1, 120, 4, 2, 8, 1);
    // R3: skewed duty cycles of A
    runWave(1'b1, 200, 6, 5, -1, 0);
    runWave(1'b1, 200, 5, 1, 40, 3);
    // R1: asynchronous reset mid-run, outputs clear before any edge
    step(1'b0, 4'b1111, 1'b0);
    #1;
    checkVal("R1", "async divOut default", divA, 0);
    checkVal("R1", "async divOut gated", divB, 0);
    checkVal("R1", "async clkOut default", outA, 0);
    checkVal("R1", "async clkOut gated", outB, 0);
    runWave(1'b0, 3, 3, 1, 0, 3);
    // R5/R7: strobe held high from reset release, release not kept over reset
    runWave(1'b1, 150, 3, 1, 0, 150);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    summary();
    $finish;
  end

endmodule